// File: doc/BRIEF.md
# Serial-In Latched Parallel Driver

This block is the logic stage of a display column driver. A serial bit stream is shifted into a chain of channel stages, one bit per clock edge while the shift strobe is high. A bank of holding latches sits behind the chain. While the latch-open input is high, the latches pass the chain contents through to the channel outputs. While it is low, they keep the last pattern on the outputs and the next line of data can be shifted in behind them. An output-enable input blanks every channel low when it is deasserted. The last stage of the chain is brought out on a serial cascade pin, so several drivers can be chained into one long column.

Two parameters choose variants. The latch style is either a transparent-equivalent latch, where outputs follow the chain in the same cycle while the latch is open, or a sampled latch that loads on a clock edge at which latch-open is high. The channel order is either forward, with channel 1 taken from the first stage, or reverse, with channel 1 taken from the last stage. The shift strobe stands for the pulses of the shift clock, so a stopped shift clock is a low strobe. Reset is synchronous and active high.

Top module: `serial_latch_driver`

## Requirements
- R1: On a rising clock edge with `shift_en` high, stage 1 (bit 0 of the chain) takes `ser_in` and each stage k takes the old value of stage k-1. With `shift_en` low the chain holds its contents.
- R2: `ser_out` always equals the last stage (stage CHANNELS) and changes only after a clock edge at which `shift_en` was high.
- R3: In the transparent style (LATCH_STYLE = LATCH_FOLLOW), while `latch_open` and `out_en` are both high, the channel outputs show the current chain contents in the same cycle, including right after a shift.
- R4: While `latch_open` stays low, the channel outputs keep their pattern even while new data is shifted into the chain.
- R5: While `out_en` is low, every bit of `chan_out` is 0 whatever the latched data. While it is high, each bit shows its latched value.
- R6: `latch_open` and `out_en` have no effect on shifting: the chain and `ser_out` evolve the same way for any values of them.
- R7: With CHAN_ORDER = ORDER_FORWARD, `chan_out[k-1]` is driven from stage k. With ORDER_REVERSE, `chan_out[k-1]` is driven from stage CHANNELS+1-k.
- R8: In the sampled style (LATCH_SAMPLED), a clock edge at which `latch_open` is high loads the latches with the chain contents present just before that edge. The outputs show them from that edge on.
- R9: A clock edge with `rst` high clears the chain and the latches to 0, overriding shifting and latching, so `ser_out` and `chan_out` read 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data entering stage 1 |
| shift_en | input | 1 | Shift strobe; one shift per edge while high |
| latch_open | input | 1 | Latch enable; high passes the chain to the latches |
| out_en | input | 1 | High shows the latched data; low forces all channels to 0 |
| chan_out | output | CHANNELS | Parallel channel outputs |
| ser_out | output | 1 | Cascade output, the last chain stage |

## Verification
The assertions assume that `ser_in`, `shift_en`, `latch_open` and `out_en` are stable around each rising clock edge and change at most once per cycle. A latch-open pulse that starts and ends between two edges would not be caught by the synchronous latch model. They also assume that reset is held for at least one edge before normal operation. The bench changes every input only on the falling clock edge, holds reset for several edges at the start, and reads the outputs one nanosecond after the inputs change. The transparent latch is exercised at that point too, before the next rising edge.

// File: rtl/sld_pkg.sv
package sld_pkg;

    typedef enum logic {
        LATCH_FOLLOW  = 1'b0,
        LATCH_SAMPLED = 1'b1
    } latch_style_e;

    typedef enum logic {
        ORDER_FORWARD = 1'b0,
        ORDER_REVERSE = 1'b1
    } chan_order_e;

    // Chain stage index (0-based) that feeds channel index k (0-based).
    function automatic int chan_src(input int k, input int width, input chan_order_e order);
        if (order == ORDER_REVERSE) begin
            return width - 1 - k;
        end
        return k;
    endfunction

endpackage

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         sdi,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] stage_d,
    output logic         tail
);
    // Next-state of the chain; bit 0 is the entry stage.
    always_comb begin
        if (shift) begin
            stage_d = {stage_q[W-2:0], sdi};
        end else begin
            stage_d = stage_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign tail = stage_q[W-1];

endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank
    import sld_pkg::*;
#(
    parameter int           W     = 32,
    parameter latch_style_e STYLE = LATCH_FOLLOW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open_i,
    input  logic [W-1:0] stage_q,
    input  logic [W-1:0] stage_d,
    output logic [W-1:0] lat_q
);
    logic [W-1:0] held_q;

    generate
        if (STYLE == LATCH_FOLLOW) begin : g_follow
            // Register keeps the value the open latch will show after the edge,
            // so closing the latch freezes exactly what was last passed through.
            always_ff @(posedge clk) begin
                if (rst) begin
                    held_q <= '0;
                end else if (open_i) begin
                    held_q <= stage_d;
                end
            end
            assign lat_q = open_i ? stage_q : held_q;
        end else begin : g_sampled
            always_ff @(posedge clk) begin
                if (rst) begin
                    held_q <= '0;
                end else if (open_i) begin
                    held_q <= stage_q;
                end
            end
            assign lat_q = held_q;
        end
    endgenerate

endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate
    import sld_pkg::*;
#(
    parameter int          W     = 32,
    parameter chan_order_e ORDER = ORDER_FORWARD
) (
    input  logic         enable,
    input  logic [W-1:0] lat_q,
    output logic [W-1:0] chan_out
);
    generate
        for (genvar k = 0; k < W; k++) begin : g_chan
            localparam int SRC = chan_src(k, W, ORDER);
            assign chan_out[k] = enable & lat_q[SRC];
        end
    endgenerate

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
    import sld_pkg::*;
#(
    parameter int           CHANNELS    = 32,
    parameter latch_style_e LATCH_STYLE = LATCH_FOLLOW,
    parameter chan_order_e  CHAN_ORDER  = ORDER_FORWARD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_in,
    input  logic                shift_en,
    input  logic                latch_open,
    input  logic                out_en,
    output logic [CHANNELS-1:0] chan_out,
    output logic                ser_out
);
    logic [CHANNELS-1:0] stage_q;
    logic [CHANNELS-1:0] stage_d;
    logic [CHANNELS-1:0] lat_q;

    sld_shift_chain #(.W(CHANNELS)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift   (shift_en),
        .sdi     (ser_in),
        .stage_q (stage_q),
        .stage_d (stage_d),
        .tail    (ser_out)
    );

    sld_latch_bank #(.W(CHANNELS), .STYLE(LATCH_STYLE)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .open_i  (latch_open),
        .stage_q (stage_q),
        .stage_d (stage_d),
        .lat_q   (lat_q)
    );

    sld_out_gate #(.W(CHANNELS), .ORDER(CHAN_ORDER)) u_gate (
        .enable   (out_en),
        .lat_q    (lat_q),
        .chan_out (chan_out)
    );

endmodule

// File: rtl/sld_checker.sv
module sld_checker
    import sld_pkg::*;
#(
    parameter int           W     = 32,
    parameter latch_style_e STYLE = LATCH_FOLLOW,
    parameter chan_order_e  ORDER = ORDER_FORWARD
) (
    input logic         clk,
    input logic         rst,
    input logic         ser_in,
    input logic         shift_en,
    input logic         latch_open,
    input logic         out_en,
    input logic [W-1:0] chan_out,
    input logic         ser_out,
    input logic [W-1:0] stage_q
);
    logic [W-1:0] view;
    always_comb begin
        for (int k = 0; k < W; k++) begin
            view[k] = (ORDER == ORDER_REVERSE) ? stage_q[W-1-k] : stage_q[k];
        end
    end

    p_shift_head_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stage_q[0] == $past(ser_in));
    p_shift_body_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stage_q[W-1:1] == $past(stage_q[W-2:0]));
    p_shift_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stage_q));
    p_cascade_step_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ser_out == $past(stage_q[W-2]));
    p_cascade_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(ser_out));
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!latch_open && !$past(latch_open) && !$past(rst) && out_en && $past(out_en))
        |-> $stable(chan_out));
    p_blank_r5: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> chan_out == '0);
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (ser_out == 1'b0 && chan_out == '0));

    generate
        if (STYLE == LATCH_FOLLOW) begin : g_follow_chk
            p_follow_r3: assert property (@(posedge clk) disable iff (rst)
                (latch_open && out_en) |-> chan_out == view);
        end else begin : g_sampled_chk
            p_sample_r8: assert property (@(posedge clk) disable iff (rst)
                latch_open |=> (!out_en || chan_out == $past(view)));
        end
    endgenerate

endmodule

bind serial_latch_driver sld_checker #(
    .W     (CHANNELS),
    .STYLE (LATCH_STYLE),
    .ORDER (CHAN_ORDER)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .shift_en   (shift_en),
    .latch_open (latch_open),
    .out_en     (out_en),
    .chan_out   (chan_out),
    .ser_out    (ser_out),
    .stage_q    (stage_q)
);

// File: tb/sim_serial_latch_driver.sv
module sim_serial_latch_driver;
    import sld_pkg::*;

    localparam int NA = 32;
    localparam int NB = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic shift_en = 1'b0;
    logic latch_open = 1'b0;
    logic out_en = 1'b0;

    logic [NA-1:0] outa;
    logic          sdoa;
    logic [NB-1:0] outb;
    logic          sdob;

    serial_latch_driver u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en),
        .latch_open(latch_open), .out_en(out_en), .chan_out(outa), .ser_out(sdoa)
    );

    serial_latch_driver #(
        .CHANNELS(NB), .LATCH_STYLE(LATCH_SAMPLED), .CHAN_ORDER(ORDER_REVERSE)
    ) u1 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en),
        .latch_open(latch_open), .out_en(out_en), .chan_out(outb), .ser_out(sdob)
    );

    // Reference state computed from the requirements
    logic [NA-1:0] sa = '0;
    logic [NA-1:0] ha = '0;
    logic [NB-1:0] sb = '0;
    logic [NB-1:0] hb = '0;
    int checks = 0;
    int fails = 0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] flip(input logic [NB-1:0] v);
        logic [NB-1:0] r;
        for (int k = 0; k < NB; k++) r[k] = v[NB-1-k];
        return r;
    endfunction

    task automatic check_all(input string tag);
        logic [NA-1:0] ea;
        logic [NB-1:0] eb;
        ea = out_en ? (latch_open ? sa : ha) : '0;
        eb = out_en ? flip(hb) : '0;
        chk({tag, " u0 channels"}, 64'(outa), 64'(ea));
        chk("R2 u0 cascade", 64'(sdoa), 64'(sa[NA-1]));
        chk("R7 R8 u1 channels", 64'(outb), 64'(eb));
        chk("R2 u1 cascade", 64'(sdob), 64'(sb[NB-1]));
    endtask

    task automatic cycle(input logic r, input logic d, input logic s,
                         input logic l, input logic o, input string tag);
        logic [NA-1:0] na;
        logic [NB-1:0] nb;
        @(negedge clk);
        rst = r; ser_in = d; shift_en = s; latch_open = l; out_en = o;
        #1;
        check_all(tag);
        @(posedge clk);
        if (r) begin
            sa = '0; ha = '0; sb = '0; hb = '0;
        end else begin
            na = s ? {sa[NA-2:0], d} : sa;
            nb = s ? {sb[NB-2:0], d} : sb;
            if (l) ha = na;
            if (l) hb = sb;
            sa = na;
            sb = nb;
        end
    endtask

    function automatic logic next_bit();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    localparam logic [NA-1:0] PAT = 32'hC3A5_0F96;
    bit done = 0;

    initial begin
        // Reset: outputs must read zero, reset overrides shift and latch (R9)
        @(posedge clk);
        @(posedge clk);
        cycle(1, 1, 1, 1, 1, "R9");
        cycle(1, 1, 1, 1, 1, "R9");
        cycle(1, 0, 0, 1, 1, "R9");

        // Fill a known pattern with the latch closed; outputs stay at zero (R4)
        for (int i = 0; i < NA; i++) cycle(0, PAT[NA-1-i], 1, 0, 1, "R4");
        // Open the latch without shifting: forward mapping of the pattern (R1, R7)
        cycle(0, 0, 0, 1, 1, "R1 R7");
        @(negedge clk); #1;
        chk("R1 R7 pattern on channels", 64'(outa), 64'(PAT));

        // Shift with the latch open: outputs follow the chain (R3)
        for (int i = 0; i < 40; i++) cycle(0, next_bit(), 1, 1, 1, "R3");
        // Close the latch and keep shifting: outputs hold (R4)
        for (int i = 0; i < 40; i++) cycle(0, next_bit(), 1, 0, 1, "R4");
        // Blanking with varying latch-open (R5)
        for (int i = 0; i < 30; i++) cycle(0, next_bit(), next_bit(), next_bit(), 0, "R5");
        cycle(0, 0, 0, 0, 1, "R5");
        // Free-running sweep of every input (R6)
        for (int i = 0; i < 3000; i++)
            cycle(0, next_bit(), next_bit(), next_bit(), next_bit(), "R6");
        // Reset in the middle of traffic (R9)
        cycle(1, 1, 1, 1, 1, "R9");
        cycle(0, 0, 0, 1, 1, "R9");
        cycle(0, 0, 0, 0, 1, "R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule